// File: doc/BRIEF.md
# Two-Cycle Search Command Front End

This block is the host-facing command stage of a ternary search engine. The host issues a search as two consecutive fast-clock cycles on a command bus that is qualified by a valid strobe. Both cycles carry a 72-bit key on the data bus. The first cycle (A) supplies the mask-register pair index and the device identifier, which later forms the upper result-address bits. The second cycle (B) supplies the comparand-pair index and the result-register index. The key must be identical in both cycles, so that it fills both halves of a 144-bit comparand pair.

When the pair of cycles is well formed, the block writes the key into the even and the odd register of the selected comparand pair. In the cycle that follows B, it presents one registered request to the match logic with a single-cycle strobe. A badly formed pair raises a sticky protocol-error flag and produces no request and no write. A readback port returns either half of any comparand pair.

Top module: `srch_cmd_front`

## Requirements
- R1: A search is accepted when `cmd_vld` is high and `cmd[1:0]` equals 2'b10 in two consecutive cycles, A then B. `req_vld` is high for exactly the one cycle that follows B.
- R2: The request's mask-pair index `req_gmr` equals {cmd[10], cmd[5:3]} as sampled in cycle A.
- R3: The request's device identifier `req_dev` equals cmd[8:6] as sampled in cycle A.
- R4: `req_cpr` equals cmd[5:2] of cycle B, and `req_ssr` equals cmd[8:6] of cycle B. `req_key` equals the key.
- R5: An accepted search writes its key into both the even half (`rd_odd`=0) and the odd half (`rd_odd`=1) of the pair given by cmd[5:2] of cycle B. No other pair changes.
- R6: If the data in cycle B differs from the data in cycle A, `proto_err` is set, no request is issued and no comparand register changes.
- R7: If cycle B has `cmd_vld` low or a code other than 2'b10, `proto_err` is set and no request is issued. That cycle is not taken as a new cycle A.
- R8: A cycle A candidate with cmd[2]=1 is rejected and sets `proto_err`. The next cycle may start a new search.
- R9: `proto_err` stays set until reset. Later well-formed searches still complete.
- R10: Back-to-back searches are sustained at one request every two cycles, and no two requests occur in adjacent cycles.
- R11: While no search is pending, cycles with `cmd_vld` low or with a code other than 2'b10 have no effect on the outputs.
- R12: After reset, `req_vld` and `proto_err` are 0 and every comparand register reads 0.
- R13: `rd_key` shows, in the same cycle, the register chosen by `rd_pair` and `rd_odd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command bus valid |
| cmd | input | 11 | Command bus: code in [1:0], fields by cycle |
| dq | input | 72 | Search key data bus |
| rd_pair | input | 4 | Comparand pair to read back |
| rd_odd | input | 1 | Readback half select: 0 even, 1 odd |
| rd_key | output | 72 | Readback data |
| req_vld | output | 1 | One-cycle search request strobe |
| req_gmr | output | 4 | Mask register pair index |
| req_dev | output | 3 | Device identifier bits |
| req_cpr | output | 4 | Comparand pair index |
| req_ssr | output | 3 | Result register index |
| req_key | output | 72 | Search key |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest situations to reach are the broken second cycles. In these a correctly started search is followed by a key that differs in one bit, by a dropped valid, or by a foreign code. The block must then reject that cycle without treating it as the start of a new search. The bench reaches these cases by sending a proper cycle A followed directly by each corrupted cycle B. It then sends a clean search and checks the request timing and the comparand readback against its reference model. It also runs an unbroken stream of searches to show that one is accepted every two cycles with no gaps.

// File: rtl/srch_cmd_pkg.sv
package srch_cmd_pkg;
  localparam int CMD_W = 11;
  localparam logic [1:0] OP_SEARCH = 2'b10;

  function automatic logic is_search(input logic vld, input logic [CMD_W-1:0] c);
    return vld && (c[1:0] == OP_SEARCH);
  endfunction

  function automatic logic [3:0] gmr_of(input logic [CMD_W-1:0] c);
    return {c[10], c[5:3]};
  endfunction

  function automatic logic [2:0] dev_of(input logic [CMD_W-1:0] c);
    return c[8:6];
  endfunction

  function automatic logic [3:0] cpr_of(input logic [CMD_W-1:0] c);
    return c[5:2];
  endfunction

  function automatic logic [2:0] ssr_of(input logic [CMD_W-1:0] c);
    return c[8:6];
  endfunction
endpackage

// File: rtl/srch_field_dec.sv
module srch_field_dec
  import srch_cmd_pkg::*;
(
  input  logic             cmd_vld,
  input  logic [CMD_W-1:0] cmd,
  output logic             srch,
  output logic             rsvd_bad,
  output logic [3:0]       gmr,
  output logic [2:0]       dev,
  output logic [3:0]       cpr,
  output logic [2:0]       ssr
);
  always_comb begin
    srch     = is_search(cmd_vld, cmd);
    rsvd_bad = cmd[2];
    gmr      = gmr_of(cmd);
    dev      = dev_of(cmd);
    cpr      = cpr_of(cmd);
    ssr      = ssr_of(cmd);
  end
endmodule

// File: rtl/srch_seq.sv
module srch_seq #(
  parameter int KEY_W  = 72,
  parameter int PAIR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [KEY_W-1:0]  dq,
  input  logic              srch,
  input  logic              rsvd_bad,
  input  logic [3:0]        gmr,
  input  logic [2:0]        dev,
  input  logic [PAIR_W-1:0] cpr,
  input  logic [2:0]        ssr,
  output logic              wr_en,
  output logic [PAIR_W-1:0] wr_idx,
  output logic [KEY_W-1:0]  wr_key,
  output logic              req_vld,
  output logic [3:0]        req_gmr,
  output logic [2:0]        req_dev,
  output logic [PAIR_W-1:0] req_cpr,
  output logic [2:0]        req_ssr,
  output logic [KEY_W-1:0]  req_key,
  output logic              proto_err
);
  logic             pend_q;
  logic [KEY_W-1:0] key_q;
  logic [3:0]       gmr_q;
  logic [2:0]       dev_q;

  // named events for assertions
  logic accept_a, fail_a, key_same, accept_b, fail_b;
  assign accept_a = !pend_q && srch && !rsvd_bad;
  assign fail_a   = !pend_q && srch && rsvd_bad;
  assign key_same = (dq == key_q);
  assign accept_b = pend_q && srch && key_same;
  assign fail_b   = pend_q && !accept_b;

  assign wr_en  = accept_b;
  assign wr_idx = cpr;
  assign wr_key = dq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      key_q     <= '0;
      gmr_q     <= '0;
      dev_q     <= '0;
      req_vld   <= 1'b0;
      req_gmr   <= '0;
      req_dev   <= '0;
      req_cpr   <= '0;
      req_ssr   <= '0;
      req_key   <= '0;
      proto_err <= 1'b0;
    end else begin
      req_vld <= 1'b0;
      if (accept_a) begin
        pend_q <= 1'b1;
        key_q  <= dq;
        gmr_q  <= gmr;
        dev_q  <= dev;
      end
      if (pend_q) pend_q <= 1'b0;
      if (accept_b) begin
        req_vld <= 1'b1;
        req_gmr <= gmr_q;
        req_dev <= dev_q;
        req_cpr <= cpr;
        req_ssr <= ssr;
        req_key <= dq;
      end
      if (fail_a || fail_b) proto_err <= 1'b1;
    end
  end

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> !req_vld);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  p_no_req_on_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cmd_vld && !key_same) |=> (!req_vld && proto_err));
  p_bad_a_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_a |=> (proto_err && !pend_q));
  p_b_not_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
  p_req_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_b |=> (req_vld && req_gmr == $past(gmr_q) && req_dev == $past(dev_q)));
endmodule

// File: rtl/srch_cpr_file.sv
module srch_cpr_file #(
  parameter int KEY_W = 72,
  parameter int PAIRS = 16,
  localparam int PAIR_W = $clog2(PAIRS),
  localparam int ENT    = 2 * PAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAIR_W-1:0] wr_idx,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [PAIR_W-1:0] rd_pair,
  input  logic              rd_odd,
  output logic [KEY_W-1:0]  rd_key
);
  logic [KEY_W-1:0] mem [ENT];
  logic [ENT-1:0]   hit;

  for (genvar g = 0; g < ENT; g++) begin : g_sel
    assign hit[g] = wr_en && (wr_idx == PAIR_W'(g / 2));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENT; i++) begin
      if (!rst_n)      mem[i] <= '0;
      else if (hit[i]) mem[i] <= wr_key;
    end
  end

  assign rd_key = mem[{rd_pair, rd_odd}];

  p_pair_halves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[{$past(wr_idx), 1'b0}] == mem[{$past(wr_idx), 1'b1}]));
  p_hit_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == (wr_en ? 2 : 0));
endmodule

// File: rtl/srch_cmd_front.sv
module srch_cmd_front
  import srch_cmd_pkg::*;
#(
  parameter int KEY_W = 72,
  parameter int PAIRS = 16,
  localparam int PAIR_W = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [KEY_W-1:0]  dq,
  input  logic [PAIR_W-1:0] rd_pair,
  input  logic              rd_odd,
  output logic [KEY_W-1:0]  rd_key,
  output logic              req_vld,
  output logic [3:0]        req_gmr,
  output logic [2:0]        req_dev,
  output logic [PAIR_W-1:0] req_cpr,
  output logic [2:0]        req_ssr,
  output logic [KEY_W-1:0]  req_key,
  output logic              proto_err
);
  logic              srch, rsvd_bad;
  logic [3:0]        gmr, cpr;
  logic [2:0]        dev, ssr;
  logic              wr_en;
  logic [PAIR_W-1:0] wr_idx;
  logic [KEY_W-1:0]  wr_key;

  srch_field_dec u_dec (
    .cmd_vld(cmd_vld), .cmd(cmd), .srch(srch), .rsvd_bad(rsvd_bad),
    .gmr(gmr), .dev(dev), .cpr(cpr), .ssr(ssr)
  );

  srch_seq #(.KEY_W(KEY_W), .PAIR_W(PAIR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .dq(dq),
    .srch(srch), .rsvd_bad(rsvd_bad), .gmr(gmr), .dev(dev),
    .cpr(cpr[PAIR_W-1:0]), .ssr(ssr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .req_vld(req_vld), .req_gmr(req_gmr), .req_dev(req_dev),
    .req_cpr(req_cpr), .req_ssr(req_ssr), .req_key(req_key),
    .proto_err(proto_err)
  );

  srch_cpr_file #(.KEY_W(KEY_W), .PAIRS(PAIRS)) u_cpr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_key(wr_key), .rd_pair(rd_pair), .rd_odd(rd_odd), .rd_key(rd_key)
  );
endmodule

// File: tb/srch_cmd_front_bench.sv
module srch_cmd_front_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld;
  logic [10:0] cmd;
  logic [71:0] dq;
  logic [3:0]  rd_pair;
  logic        rd_odd;
  logic [71:0] rd_key, req_key;
  logic        req_vld, proto_err;
  logic [3:0]  req_gmr, req_cpr;
  logic [2:0]  req_dev, req_ssr;

  always #10 clk = ~clk;

  srch_cmd_front u_srch_cmd_front (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .dq(dq),
    .rd_pair(rd_pair), .rd_odd(rd_odd), .rd_key(rd_key),
    .req_vld(req_vld), .req_gmr(req_gmr), .req_dev(req_dev),
    .req_cpr(req_cpr), .req_ssr(req_ssr), .req_key(req_key),
    .proto_err(proto_err)
  );

  int checks = 0, failures = 0, pulses = 0;

  // reference model state
  bit          m_pend, m_err, m_vld;
  logic [71:0] m_key, m_rkey;
  logic [3:0]  m_gmr, m_rgmr, m_rcpr;
  logic [2:0]  m_dev, m_rdev, m_rssr;
  logic [71:0] m_cpr [32];

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_a(input logic [3:0] g, input logic [2:0] d, input bit b2);
    return {g[3], 1'b0, d, g[2:0], b2, 2'b10};
  endfunction
  function automatic logic [10:0] mk_b(input logic [3:0] c, input logic [2:0] s);
    return {2'b00, s, c, 2'b10};
  endfunction

  task automatic model_reset();
    m_pend = 0; m_err = 0; m_vld = 0; m_key = '0;
    for (int i = 0; i < 32; i++) m_cpr[i] = '0;
  endtask

  task automatic model_step(input bit v, input logic [10:0] c, input logic [71:0] d);
    bit s;
    s = v && (c[1:0] == 2'b10);
    m_vld = 0;
    if (!m_pend) begin
      if (s && c[2]) m_err = 1;
      else if (s) begin
        m_pend = 1; m_key = d; m_gmr = {c[10], c[5:3]}; m_dev = c[8:6];
      end
    end else begin
      m_pend = 0;
      if (s && d == m_key) begin
        m_vld = 1; m_rgmr = m_gmr; m_rdev = m_dev;
        m_rcpr = c[5:2]; m_rssr = c[8:6]; m_rkey = d;
        m_cpr[{c[5:2], 1'b0}] = d; m_cpr[{c[5:2], 1'b1}] = d;
      end else m_err = 1;
    end
  endtask

  task automatic compare();
    check(req_vld == m_vld, "R1 req_vld", 72'(req_vld), 72'(m_vld));
    if (m_vld) begin
      check(req_gmr == m_rgmr, "R2 req_gmr", 72'(req_gmr), 72'(m_rgmr));
      check(req_dev == m_rdev, "R3 req_dev", 72'(req_dev), 72'(m_rdev));
      check(req_cpr == m_rcpr && req_ssr == m_rssr, "R4 req_cpr/ssr",
            72'({req_cpr, req_ssr}), 72'({m_rcpr, m_rssr}));
      check(req_key == m_rkey, "R4 req_key", req_key, m_rkey);
    end
    check(proto_err == m_err, "R9 proto_err", 72'(proto_err), 72'(m_err));
    check(rd_key == m_cpr[{rd_pair, rd_odd}], "R13 rd_key", rd_key, m_cpr[{rd_pair, rd_odd}]);
    if (req_vld) pulses++;
  endtask

  task automatic cyc(input bit v, input logic [10:0] c, input logic [71:0] d);
    cmd_vld = v; cmd = c; dq = d;
    model_step(v, c, d);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_vld = 0; cmd = '0; dq = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    check(!req_vld && !proto_err, "R12 reset outputs", 72'({req_vld, proto_err}), 72'(0));
  endtask

  task automatic search(input logic [3:0] g, input logic [2:0] dv, input logic [3:0] c,
                        input logic [2:0] s, input logic [71:0] k);
    cyc(1, mk_a(g, dv, 0), k);
    cyc(1, mk_b(c, s), k);
  endtask

  localparam logic [71:0] K1 = 72'hA5_0123_4567_89AB_CDEF;
  localparam logic [71:0] K2 = 72'h3C_FEDC_BA98_7654_3210;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rd_pair = 0; rd_odd = 0;
    do_reset();
    // R12: comparand registers clear
    for (int p = 0; p < 16; p++) begin
      rd_pair = 4'(p); rd_odd = p[0];
      @(negedge clk);
      check(rd_key == 72'd0, "R12 cpr reset", rd_key, 72'd0);
    end
    // R11: idle noise
    cyc(0, mk_a(4'h3, 3'd1, 0), K1);
    cyc(1, 11'h001, K1);
    cyc(1, 11'h003, K2);
    cyc(1, 11'h000, K2);
    check(!proto_err && pulses == 0, "R11 idle noise ignored", 72'({proto_err, 4'(pulses)}), 72'(0));
    // R1..R5 single search
    rd_pair = 4'd9; rd_odd = 0;
    search(4'b1011, 3'd5, 4'd9, 3'd6, K1);
    check(pulses == 1, "R1 one request", 72'(pulses), 72'd1);
    cyc(0, 11'h0, '0);
    rd_odd = 1; @(negedge clk);
    check(rd_key == K1, "R5 odd half", rd_key, K1);
    rd_odd = 0; @(negedge clk);
    check(rd_key == K1, "R5 even half", rd_key, K1);
    rd_pair = 4'd8; @(negedge clk);
    check(rd_key == 72'd0, "R5 neighbour untouched", rd_key, 72'd0);
    // R10 back-to-back
    pulses = 0;
    rd_pair = 4'd2;
    for (int i = 0; i < 4; i++)
      search(4'(i * 5), 3'(i), 4'(i + 1), 3'(7 - i), K2 ^ 72'(i));
    check(pulses == 4, "R10 four requests in eight cycles", 72'(pulses), 72'd4);
    // R6 mismatch
    rd_pair = 4'd12;
    pulses = 0;
    cyc(1, mk_a(4'h1, 3'd2, 0), K1);
    cyc(1, mk_b(4'd12, 3'd1), K1 ^ 72'h1);
    check(proto_err && pulses == 0, "R6 mismatch flagged", 72'({proto_err, 4'(pulses)}), 72'h10);
    check(rd_key == 72'd0, "R6 pair unwritten", rd_key, 72'd0);
    // R9 sticky, later search still works
    search(4'h2, 3'd3, 4'd12, 3'd2, K2);
    check(proto_err && pulses == 1, "R9 sticky and still searching", 72'({proto_err, 4'(pulses)}), 72'h11);
    // R7 B without valid
    do_reset();
    pulses = 0;
    cyc(1, mk_a(4'h4, 3'd4, 0), K1);
    cyc(0, mk_b(4'd3, 3'd3), K1);
    check(proto_err && pulses == 0, "R7 missing valid", 72'({proto_err, 4'(pulses)}), 72'h10);
    // R7 B with foreign code: then this cycle not a new A
    do_reset();
    cyc(1, mk_a(4'h4, 3'd4, 0), K1);
    cyc(1, 11'h001, K1);
    cyc(1, mk_b(4'd3, 3'd3), K1);
    cyc(0, 11'h0, '0);
    check(proto_err && pulses == 0, "R7 foreign code", 72'({proto_err, 4'(pulses)}), 72'h10);
    // R8 reserved bit in A
    do_reset();
    pulses = 0;
    cyc(1, mk_a(4'h6, 3'd1, 1), K2);
    check(proto_err == 1, "R8 reserved bit flagged", 72'(proto_err), 72'd1);
    search(4'h6, 3'd1, 4'd5, 3'd4, K2);
    check(pulses == 1, "R8 next cycle starts search", 72'(pulses), 72'd1);
    cyc(0, 11'h0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule